// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned or two's-complement operands and a carry-in in pure combinational logic. The operands are cut into four 4-bit groups. Inside each group every bit position forms a generate term and a propagate term. A first-level lookahead network turns these terms into the carries inside the group, plus one group generate and one group propagate.

A second-level lookahead network takes the four group terms and the external carry-in. It produces the carry into each group and the final carry-out, so no carry ripples from one group to the next. The adder also exports the generate and propagate of the whole 16-bit word. A wider adder can therefore be built by feeding several of these units into one more lookahead level.

The block holds no state. Its outputs settle within the same clock period as its inputs, and it is meant to sit on a datapath path between registers owned by the surrounding logic.

Top module: `cla_adder16`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum} equals op_a + op_b + carry_in, computed as a 17-bit unsigned value.
- R2: With op_b all zeros and carry_in low, sum equals op_a and carry_out is low.
- R3: word_prop is high exactly when every bit of op_a XOR op_b is one, meaning each position passes its incoming carry on.
- R4: word_gen is high exactly when op_a + op_b with carry_in low carries out of bit 15, whatever carry_in is actually applied.
- R5: carry_out equals word_gen OR (word_prop AND carry_in), so the unit can be cascaded through its word terms.
- R6: A carry entering at bit 0 crosses every group boundary: with op_a XOR op_b all ones and carry_in high, sum is zero and carry_out is high; with carry_in low, sum is all ones and carry_out is low.
- R7: word_gen and word_prop are never high together.
- R8: The outputs are a function of the present inputs only. After an input change the outputs take their new values without any clock edge, and earlier inputs have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |
| word_gen | output | 1 | The word generates a carry by itself |
| word_prop | output | 1 | The word passes carry_in straight through |

## Verification
The block holds no state, so a wrong internal term shows at the ports as soon as the inputs settle. A bad bit-level term corrupts a sum bit. A bad group term in the second level corrupts the lowest sum bit of every higher group and can also corrupt carry_out. Those faults only appear when a carry has to cross a group boundary. For that reason the stimulus includes patterns that propagate across whole groups and patterns that generate a carry at exactly one group edge, alongside the random vectors. Every vector is checked within the same clock period in which it is applied.

// File: rtl/cla_pkg.sv
// Package: shared widths and small helpers for the two-level lookahead adder.
// Assumes: the group width and group count are small (each at most 8), so the
// flattened sum-of-products carry equations stay shallow.
package cla_pkg;
    localparam int unsigned GROUP_W  = 4;
    localparam int unsigned N_GROUPS = 4;
    localparam int unsigned WORD_W   = GROUP_W * N_GROUPS;

    typedef logic [WORD_W-1:0] word_t;

    // A generate/propagate pair travelling between lookahead levels.
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;
endpackage

// File: rtl/cla_lookahead.sv
// Module: cla_lookahead
// Forms the carry into each of N positions, and the carry out of the last one,
// from per-position generate/propagate terms and an incoming carry. Every
// carry is a flat sum of products, so the depth does not grow with the
// position index. It also reports the combined generate/propagate of all N
// positions, so the same unit serves both the bit level and the group level.
// Assumes: prop_i is an exclusive-or propagate, so gen_i and prop_i are never
// both high at the same position.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         c_i,
    output logic [N-1:0] c_pos_o,
    output logic         c_last_o,
    output logic         gen_o,
    output logic         prop_o
);
    logic [N:0] carry;

    // Carry into position i: either carry-in survives every propagate below
    // i, or some position j generates and every position between j and i
    // propagates.
    always_comb begin
        carry[0] = c_i;
        for (int i = 1; i <= N; i++) begin
            logic acc;
            logic term;
            acc = c_i;
            for (int j = 0; j < i; j++) acc = acc & prop_i[j];
            for (int j = 0; j < i; j++) begin
                term = gen_i[j];
                for (int k = j + 1; k < i; k++) term = term & prop_i[k];
                acc = acc | term;
            end
            carry[i] = acc;
        end
    end

    // Combined generate: the top position generates, or a lower one does and
    // everything above it propagates.
    always_comb begin
        gen_o = 1'b0;
        for (int j = 0; j < N; j++) begin
            logic term;
            term = gen_i[j];
            for (int k = j + 1; k < N; k++) term = term & prop_i[k];
            gen_o = gen_o | term;
        end
    end

    // Combined propagate: every position passes its carry on.
    always_comb prop_o = &prop_i;

    assign c_pos_o  = carry[N-1:0];
    assign c_last_o = carry[N];

    // Checks on the combined terms against the carry chain.
    always_comb begin
        if (!$isunknown({gen_i, prop_i, c_i})) begin
            AST_LA_PASS: assert (!prop_o || (c_last_o == c_i)) else $error("propagate path lost carry-in"); // R5
            AST_LA_GEN: assert (!gen_o || c_last_o) else $error("generate did not force carry"); // R4
            AST_LA_EXCL: assert (!(gen_o && prop_o)) else $error("generate and propagate both high"); // R7
        end
    end
endmodule

// File: rtl/cla_group.sv
// Module: cla_group
// One W-bit group. Each bit forms its generate (AND) and propagate (XOR).
// A first-level lookahead turns these into the carry into every bit. The sum
// bit is the propagate XOR the carry into that bit. The group exports its
// combined generate/propagate for the second level.
// Assumes: grp_cin arrives from the second-level lookahead, not from the
// neighbouring group.
module cla_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         grp_cin,
    output logic [W-1:0] sum_o,
    output cla_pkg::gp_t grp_gp_o
);
    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_cin;
    logic         grp_cout;

    // Per-bit generate/propagate terms and sum bits.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_gen[i]  = a_i[i] & b_i[i];
        assign bit_prop[i] = a_i[i] ^ b_i[i];
        assign sum_o[i]    = bit_prop[i] ^ bit_cin[i];
    end

    cla_lookahead #(.N(W)) u_la (
        .gen_i    (bit_gen),
        .prop_i   (bit_prop),
        .c_i      (grp_cin),
        .c_pos_o  (bit_cin),
        .c_last_o (grp_cout),
        .gen_o    (grp_gp_o.gen),
        .prop_o   (grp_gp_o.prop)
    );

    // The group on its own must add correctly given its carry-in.
    always_comb begin
        if (!$isunknown({a_i, b_i, grp_cin})) begin
            AST_GRP_SUM: assert ({grp_cout, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, grp_cin})) else $error("group sum mismatch"); // R1
        end
    end
endmodule

// File: rtl/cla_adder16.sv
// Module: cla_adder16
// Top of the two-level lookahead adder. Four groups each compute their own
// internal carries. A second-level lookahead takes the group generate and
// propagate terms plus carry_in and supplies every group's carry-in and the
// final carry-out. The word-level terms are exported for further cascading.
// Assumes: purely combinational use between registers owned by the caller.
module cla_adder16
    import cla_pkg::*;
(
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic        carry_in,
    output logic [15:0] sum,
    output logic        carry_out,
    output logic        word_gen,
    output logic        word_prop
);
    gp_t  [N_GROUPS-1:0]  grp_gp;
    logic [N_GROUPS-1:0]  grp_gen;
    logic [N_GROUPS-1:0]  grp_prop;
    logic [N_GROUPS-1:0]  grp_cin;

    // One group per slice of the word, each fed by the second level.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        cla_group #(.W(GROUP_W)) u_grp (
            .a_i      (op_a[g*GROUP_W +: GROUP_W]),
            .b_i      (op_b[g*GROUP_W +: GROUP_W]),
            .grp_cin  (grp_cin[g]),
            .sum_o    (sum[g*GROUP_W +: GROUP_W]),
            .grp_gp_o (grp_gp[g])
        );
        assign grp_gen[g]  = grp_gp[g].gen;
        assign grp_prop[g] = grp_gp[g].prop;
    end

    // Second lookahead level over the group terms.
    cla_lookahead #(.N(N_GROUPS)) u_top_la (
        .gen_i    (grp_gen),
        .prop_i   (grp_prop),
        .c_i      (carry_in),
        .c_pos_o  (grp_cin),
        .c_last_o (carry_out),
        .gen_o    (word_gen),
        .prop_o   (word_prop)
    );

    // Whole-word arithmetic and cascade relation at the ports.
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            AST_ADD_MATCH: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in})) else $error("word sum mismatch"); // R1
            AST_CASCADE: assert (carry_out == (word_gen | (word_prop & carry_in))) else $error("cascade relation broken"); // R5
            AST_WORD_EXCL: assert (!(word_gen && word_prop)) else $error("word generate and propagate both high"); // R7
        end
    end
endmodule

// File: tb/sim_cla_adder16.sv
module sim_cla_adder16;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum;
    logic        carry_out;
    logic        word_gen;
    logic        word_prop;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder16 u0 (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out),
        .word_gen(word_gen), .word_prop(word_prop)
    );

    function automatic logic [16:0] exp_total(logic [15:0] a, logic [15:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {16'd0, c};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, op_a, op_b, carry_in);
        end
    endtask

    // Apply after a rising edge, sample at the falling edge.
    task automatic apply_check(logic [15:0] a, logic [15:0] b, logic c);
        logic [16:0] t;
        logic [16:0] t0;
        @(posedge clk);
        op_a = a; op_b = b; carry_in = c;
        @(negedge clk);
        t  = exp_total(a, b, c);
        t0 = exp_total(a, b, 1'b0);
        chk("R1", {15'd0, carry_out, sum}, {15'd0, t});
        chk("R3", {31'd0, word_prop}, {31'd0, &(a ^ b)});
        chk("R4", {31'd0, word_gen}, {31'd0, t0[16]});
        chk("R5", {31'd0, carry_out}, {31'd0, t0[16] | (&(a ^ b) & c)});
        chk("R7", {31'd0, word_gen & word_prop}, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Idle inputs: zero sum, no carry, word passes nothing
        @(negedge clk);
        chk("R1", {15'd0, carry_out, sum}, 32'd0);
        chk("R3", {31'd0, word_prop}, 32'd0);

        // R2: identity with zero addend
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            apply_check(a, 16'h0000, 1'b0);
            chk("R2", {15'd0, carry_out, sum}, {16'd0, a});
        end

        // R6: carry crosses every group boundary
        apply_check(16'hFFFF, 16'h0000, 1'b1);
        chk("R6", {15'd0, carry_out, sum}, 32'h10000);
        apply_check(16'hA5C3, 16'h5A3C, 1'b1);
        chk("R6", {15'd0, carry_out, sum}, 32'h10000);
        apply_check(16'hA5C3, 16'h5A3C, 1'b0);
        chk("R6", {15'd0, carry_out, sum}, 32'h0FFFF);

        // Generate exactly at each group edge, propagate above it
        for (int g = 0; g < 4; g++) begin
            logic [15:0] a;
            a = 16'hFFFF << (4 * g);
            apply_check(a, 16'h0001 << (4 * g), 1'b0);
            apply_check(16'h0FFF >> (4 * (3 - g)) << 4, 16'h0010, 1'b1);
        end

        // Corner patterns
        apply_check(16'hFFFF, 16'hFFFF, 1'b1);
        apply_check(16'h8000, 16'h8000, 1'b0);
        apply_check(16'h7FFF, 16'h0001, 1'b0);
        apply_check(16'h0000, 16'h0000, 1'b1);
        apply_check(16'h00FF, 16'hFF00, 1'b0);

        // Constrained random: bias some operands toward long propagate runs
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            a = 16'($urandom);
            b = (i % 3 == 0) ? (~a ^ (16'h1 << ($urandom % 16))) : 16'($urandom);
            apply_check(a, b, 1'($urandom));
        end

        // R8: outputs follow a mid-cycle change without a clock edge
        @(posedge clk);
        op_a = 16'h1234; op_b = 16'h1111; carry_in = 1'b0;
        #1;
        chk("R8", {15'd0, carry_out, sum}, {15'd0, exp_total(16'h1234, 16'h1111, 1'b0)});
        op_a = 16'hFFF0; op_b = 16'h0010; carry_in = 1'b1;
        #1;
        chk("R8", {15'd0, carry_out, sum}, {15'd0, exp_total(16'hFFF0, 16'h0010, 1'b1)});

        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule